// File: doc/BRIEF.md
# Two-Error-Correcting BCH Page Decoder

This block repairs a 256-bit memory page that was stored with 18 check bits. It receives the whole 274-bit codeword as one wide vector. Without a clock and in a single combinational pass, it returns the repaired payload, the number of bits it flipped, and a flag for patterns it cannot repair. The code is a shortened binary BCH code over GF(2^9). The field is built on x^9 + x^4 + 1, and codewords have alpha and alpha^3 as roots. Any pattern of one or two flipped bits is repaired, wherever those bits fall in the payload or in the check field.

Three unrolled stages do the work. The first forms the odd syndromes S1 and S3 with XOR trees over the received bits. The second builds an error-locator polynomial L(x) = S1 + S1^2·x + (S3 + S1^3)·x^2, which needs no field inversion. The third evaluates L at alpha^-i for every bit position i in parallel, and a bit is in error wherever that value is zero. The GF multipliers are bit-parallel shift-and-reduce networks. The payload width is a parameter, and the codeword length follows from it.

Top module: `bch2_page_decoder`

## Requirements
- R1: Codeword bit i is the coefficient of x^i. Bits [17:0] hold the check bits and bits [273:18] hold the payload, and `data_out` returns bits [273:18] after repair. A valid word is divisible by the product of the minimal polynomials of alpha and alpha^3 over GF(2^9) with x^9+x^4+1.
- R2: For a valid codeword, `err_count` is 0, `uncorrectable` is 0 and `data_out` equals the received payload.
- R3: For exactly one flipped bit at any position 0..273, `data_out` equals the original payload, `err_count` is 1 and `uncorrectable` is 0.
- R4: For exactly two flipped bits at any two distinct positions, including one in each field, `data_out` equals the original payload, `err_count` is 2 and `uncorrectable` is 0.
- R5: When S1 is zero and S3 is not, `uncorrectable` is 1, `err_count` is 0 and `data_out` equals the received payload.
- R6: When the number of located positions does not match the syndrome class (one expected for S3 = S1^3, two otherwise), `uncorrectable` is 1 and the received payload is passed through unmodified.
- R7: `err_count` is 0 whenever `uncorrectable` is 1. When `uncorrectable` is 0, `data_out` differs from the received payload in at most `err_count` bits. Three flipped bits never yield `err_count` 0 with `uncorrectable` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_word | input | 274 | Received codeword, bit i = coefficient of x^i |
| data_out | output | 256 | Repaired payload (codeword bits 273..18) |
| err_count | output | 2 | Number of bits repaired: 0, 1 or 2 |
| uncorrectable | output | 1 | Pattern detected but not repairable |

## Verification
The test that matters most is one where a single evaluation has to repair a payload bit and also locate a root in the check field. That is provoked with two-bit patterns that put one flip on each side of bit 18. It is judged by an exact payload match together with a count of 2. Some three-flip patterns make S1 vanish while S3 does not. The bench finds those position triples arithmetically and injects them, so detection and pass-through are exercised at once. Random three-flip patterns then test that, whenever a miscorrection is reported, it touches no more bits than the count it gives.

// File: rtl/bch2_pkg.sv
package bch2_pkg;

    // Field GF(2^9), generated by x^9 + x^4 + 1
    localparam int M    = 9;
    localparam int ORD  = (1 << M) - 1;
    localparam logic [M-1:0] POLY_LO = 9'h011;

    typedef enum logic [1:0] {
        CLS_CLEAN = 2'd0,
        CLS_ONE   = 2'd1,
        CLS_TWO   = 2'd2,
        CLS_BAD   = 2'd3
    } err_class_e;

    typedef struct packed {
        logic [M-1:0] s1;
        logic [M-1:0] s3;
    } synd_t;

    typedef struct packed {
        logic [M-1:0] c0;
        logic [M-1:0] c1;
        logic [M-1:0] c2;
        err_class_e   cls;
    } locator_t;

    // Bit-parallel shift-and-reduce product; unrolls into an XOR/AND network
    function automatic logic [M-1:0] gf_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] acc;
        logic [M-1:0] sh;
        acc = '0;
        sh  = a;
        for (int k = 0; k < M; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = {sh[M-2:0], 1'b0} ^ (sh[M-1] ? POLY_LO : '0);
        end
        return acc;
    endfunction

    // alpha^e, evaluated at elaboration only
    function automatic logic [M-1:0] gf_pow(input int e);
        logic [M-1:0] r;
        r = {{(M-1){1'b0}}, 1'b1};
        for (int k = 0; k < e; k++)
            r = {r[M-2:0], 1'b0} ^ (r[M-1] ? POLY_LO : '0);
        return r;
    endfunction

endpackage

// File: rtl/bch2_gf_mul.sv
module bch2_gf_mul
    import bch2_pkg::*;
(
    input  logic [M-1:0] op_a,
    input  logic [M-1:0] op_b,
    output logic [M-1:0] prod
);
    logic [M-1:0] pp [M];

    // partial products: op_a * alpha^k, gated by op_b[k]
    generate
        for (genvar k = 0; k < M; k++) begin : g_pp
            logic [M-1:0] a_shift;
            if (k == 0) begin : g_base
                assign a_shift = op_a;
            end else begin : g_step
                assign a_shift = {g_pp[k-1].a_shift[M-2:0], 1'b0}
                               ^ (g_pp[k-1].a_shift[M-1] ? POLY_LO : '0);
            end
            assign pp[k] = op_b[k] ? a_shift : '0;
        end
    endgenerate

    always_comb begin
        prod = '0;
        for (int k = 0; k < M; k++) prod = prod ^ pp[k];
    end
endmodule

// File: rtl/bch2_syndrome.sv
module bch2_syndrome
    import bch2_pkg::*;
#(
    parameter int N_CW = 274
) (
    input  logic [N_CW-1:0] cw,
    output synd_t           synd
);
    logic [M-1:0] t1 [N_CW];
    logic [M-1:0] t3 [N_CW];

    generate
        for (genvar i = 0; i < N_CW; i++) begin : g_bit
            localparam logic [M-1:0] P1 = gf_pow(i % ORD);
            localparam logic [M-1:0] P3 = gf_pow((3 * i) % ORD);
            assign t1[i] = cw[i] ? P1 : '0;
            assign t3[i] = cw[i] ? P3 : '0;
        end
    endgenerate

    always_comb begin
        synd = '0;
        for (int i = 0; i < N_CW; i++) begin
            synd.s1 = synd.s1 ^ t1[i];
            synd.s3 = synd.s3 ^ t3[i];
        end
    end

    // an all-zero word is a codeword
    always_comb begin
        if (cw == '0)
            a_r2_zero_word_clean: assert (synd.s1 == '0 && synd.s3 == '0);
    end
endmodule

// File: rtl/bch2_locator.sv
module bch2_locator
    import bch2_pkg::*;
(
    input  synd_t    synd,
    output locator_t loc
);
    logic [M-1:0] s1_sq;
    logic [M-1:0] s1_cu;

    bch2_gf_mul u_square (.op_a(synd.s1), .op_b(synd.s1), .prod(s1_sq));
    bch2_gf_mul u_cube   (.op_a(s1_sq),   .op_b(synd.s1), .prod(s1_cu));

    // L(x) scaled by S1: no inversion anywhere
    always_comb begin
        loc.c0 = synd.s1;
        loc.c1 = s1_sq;
        loc.c2 = synd.s3 ^ s1_cu;
        if (synd.s1 == '0)
            loc.cls = (synd.s3 == '0) ? CLS_CLEAN : CLS_BAD;
        else
            loc.cls = (loc.c2 == '0) ? CLS_ONE : CLS_TWO;
    end
endmodule

// File: rtl/bch2_root_search.sv
module bch2_root_search
    import bch2_pkg::*;
#(
    parameter int N_CW = 274
) (
    input  locator_t        loc,
    output logic [N_CW-1:0] hit
);
    generate
        for (genvar i = 0; i < N_CW; i++) begin : g_pos
            localparam int INV1 = (ORD - (i % ORD)) % ORD;
            localparam logic [M-1:0] B1 = gf_pow(INV1);
            localparam logic [M-1:0] B2 = gf_pow((2 * INV1) % ORD);
            logic [M-1:0] val;
            assign val    = loc.c0 ^ gf_mul(loc.c1, B1) ^ gf_mul(loc.c2, B2);
            assign hit[i] = (val == '0);
        end
    endgenerate

    // only a nonzero x^2 term left: L never vanishes at a nonzero point
    always_comb begin
        if (loc.c0 == '0 && loc.c1 == '0 && loc.c2 != '0)
            a_r5_no_root_when_s1_zero: assert (hit == '0);
    end
endmodule

// File: rtl/bch2_page_decoder.sv
module bch2_page_decoder
    import bch2_pkg::*;
#(
    parameter int K_DATA = 256,
    localparam int N_CW  = K_DATA + 2 * M
) (
    input  logic [N_CW-1:0]   rx_word,
    output logic [K_DATA-1:0] data_out,
    output logic [1:0]        err_count,
    output logic              uncorrectable
);
    localparam int P_BITS = 2 * M;
    localparam int RW     = $clog2(N_CW + 1);

    synd_t           synd;
    locator_t        loc;
    logic [N_CW-1:0] hit;
    logic [RW-1:0]   n_roots;
    logic            fix_en;
    logic [K_DATA-1:0] rx_data;

    bch2_syndrome #(.N_CW(N_CW)) u_synd (.cw(rx_word), .synd(synd));
    bch2_locator                 u_loc  (.synd(synd), .loc(loc));
    bch2_root_search #(.N_CW(N_CW)) u_roots (.loc(loc), .hit(hit));

    assign rx_data = rx_word[N_CW-1:P_BITS];
    assign n_roots = RW'($countones(hit));

    always_comb begin
        uncorrectable = 1'b0;
        err_count     = 2'd0;
        unique case (loc.cls)
            CLS_CLEAN: err_count = 2'd0;
            CLS_ONE: begin
                if (n_roots == RW'(1)) err_count = 2'd1;
                else                   uncorrectable = 1'b1;
            end
            CLS_TWO: begin
                if (n_roots == RW'(2)) err_count = 2'd2;
                else                   uncorrectable = 1'b1;
            end
            default: uncorrectable = 1'b1;
        endcase
        fix_en   = (err_count != 2'd0);
        data_out = rx_data ^ (fix_en ? hit[N_CW-1:P_BITS] : '0);
    end

    always_comb begin
        if (uncorrectable)
            a_r7_flag_means_zero_count: assert (err_count == 2'd0);
        if (!uncorrectable && err_count == 2'd0)
            a_r2_clean_passthrough: assert (data_out == rx_data);
        if (!uncorrectable)
            a_r7_change_bounded: assert ($countones(data_out ^ rx_data) <= int'(err_count));
        if (uncorrectable)
            a_r6_flagged_unmodified: assert (data_out == rx_data);
    end
endmodule

// File: tb/test_bch2_page_decoder.sv
module test_bch2_page_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int K  = 256;
    localparam int PB = 18;
    localparam int N  = K + PB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] rx_word;
    logic [K-1:0] data_out;
    logic [1:0]   err_count;
    logic         uncorrectable;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int gexp [0:510];
    int glog [0:511];
    logic [PB:0] gen;

    always #(CLK_PERIOD/2) clk = ~clk;

    bch2_page_decoder i_bch2_page_decoder (
        .rx_word(rx_word), .data_out(data_out),
        .err_count(err_count), .uncorrectable(uncorrectable)
    );

    function automatic int fmul(int a, int b);
        if (a == 0 || b == 0) return 0;
        return gexp[(glog[a] + glog[b]) % 511];
    endfunction

    task automatic build_field();
        gexp[0] = 1;
        glog[1] = 0;
        glog[0] = -1;
        for (int k = 1; k < 511; k++) begin
            int v;
            v = gexp[k-1] << 1;
            if (v & 512) v = (v & 511) ^ 17;
            gexp[k] = v;
            glog[v] = k;
        end
    endtask

    // generator = minpoly(alpha) * minpoly(alpha^3)
    task automatic build_generator();
        int mp [0:9];
        logic [9:0] m1, m3;
        for (int k = 0; k < 10; k++) mp[k] = 0;
        mp[0] = 1;
        for (int j = 0; j < 9; j++) begin
            int root;
            int nx [0:9];
            root = gexp[(3 * (1 << j)) % 511];
            for (int k = 0; k < 10; k++)
                nx[k] = fmul(mp[k], root) ^ ((k > 0) ? mp[k-1] : 0);
            for (int k = 0; k < 10; k++) mp[k] = nx[k];
        end
        for (int k = 0; k < 10; k++) m3[k] = mp[k][0];
        m1 = 10'b1000010001;
        gen = '0;
        for (int a = 0; a < 10; a++)
            if (m1[a]) gen = gen ^ ({9'b0, m3} << a);
    endtask

    function automatic logic [N-1:0] encode(logic [K-1:0] d);
        logic [PB-1:0] rem;
        logic fb;
        rem = '0;
        for (int i = K - 1; i >= 0; i--) begin
            fb  = d[i] ^ rem[PB-1];
            rem = {rem[PB-2:0], 1'b0};
            if (fb) rem = rem ^ gen[PB-1:0];
        end
        return {d, rem};
    endfunction

    function automatic logic [K-1:0] rand_data();
        logic [K-1:0] d;
        for (int w = 0; w < K / 32; w++) d[w*32 +: 32] = $urandom;
        return d;
    endfunction

    task automatic apply(logic [N-1:0] w);
        @(negedge clk);
        rx_word = w;
        #(CLK_PERIOD/4);
    endtask

    task automatic fail_line(string req, string what, int act, int exp);
        n_fail++;
        $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    endtask

    // exact repair expected for 0..2 flips
    task automatic check_exact(string req, logic [K-1:0] orig, int nerr);
        n_checks++;
        if (data_out !== orig || err_count !== 2'(nerr) || uncorrectable !== 1'b0) begin
            n_fail++;
            $display("FAIL %s data_ok=%0d count actual %0d expected %0d flag actual %0d expected 0",
                     req, data_out === orig, err_count, nerr, uncorrectable);
        end
    endtask

    // three flips: either flagged with passthrough, or bounded miscorrection
    task automatic check_three(logic [N-1:0] w);
        n_checks++;
        if (uncorrectable) begin
            if (data_out !== w[N-1:PB]) fail_line("R6", "flagged word modified", 1, 0);
            else if (err_count !== 2'd0) fail_line("R7", "count while flagged", err_count, 0);
        end else begin
            if (err_count == 2'd0) fail_line("R7", "three flips reported clean", 0, 1);
            else if ($countones(data_out ^ w[N-1:PB]) > err_count)
                fail_line("R7", "bits changed beyond count",
                          $countones(data_out ^ w[N-1:PB]), err_count);
        end
    endtask

    task automatic pick_distinct(int cnt, output int p [3]);
        for (int a = 0; a < cnt; a++) begin
            bit again;
            do begin
                p[a] = $urandom_range(N - 1, 0);
                again = 0;
                for (int b = 0; b < a; b++) if (p[b] == p[a]) again = 1;
            end while (again);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fail_line("ALL", "watchdog expired", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [K-1:0] d;
        logic [N-1:0] cw, w;
        int p [3];
        int found;

        rx_word = '0;
        build_field();
        build_generator();
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R2: idle all-zero input, the reset-time state
        apply('0);
        check_exact("R2", '0, 0);

        // R1/R2: clean codewords with various payloads
        apply(encode({K{1'b1}}));
        check_exact("R1", {K{1'b1}}, 0);
        for (int v = 0; v < 20; v++) begin
            d = rand_data();
            apply(encode(d));
            check_exact("R2", d, 0);
        end

        // R3: every single position, including check bits 0..17
        d  = rand_data();
        cw = encode(d);
        for (int i = 0; i < N; i++) begin
            w = cw;
            w[i] = ~w[i];
            apply(w);
            check_exact("R3", d, 1);
        end

        // R4: one flip in check field plus one in payload (same evaluation)
        for (int v = 0; v < 150; v++) begin
            d  = rand_data();
            cw = encode(d);
            w  = cw;
            w[$urandom_range(PB - 1, 0)]  ^= 1'b1;
            w[$urandom_range(N - 1, PB)] ^= 1'b1;
            apply(w);
            check_exact("R4", d, 2);
        end

        // R4: two random distinct positions, boundary pair first
        d  = rand_data();
        cw = encode(d);
        w  = cw; w[0] ^= 1'b1; w[N-1] ^= 1'b1;
        apply(w);
        check_exact("R4", d, 2);
        for (int v = 0; v < 300; v++) begin
            d  = rand_data();
            cw = encode(d);
            pick_distinct(2, p);
            w = cw; w[p[0]] ^= 1'b1; w[p[1]] ^= 1'b1;
            apply(w);
            check_exact("R4", d, 2);
        end

        // R5: triples with alpha^a + alpha^b + alpha^c = 0 (S1 vanishes)
        found = 0;
        for (int a = 0; a < N && found < 6; a++)
            for (int b = a + 1; b < N && found < 6; b++) begin
                int c;
                c = glog[gexp[a] ^ gexp[b]];
                if (c > b && c < N) begin
                    d  = rand_data();
                    cw = encode(d);
                    w  = cw; w[a] ^= 1'b1; w[b] ^= 1'b1; w[c] ^= 1'b1;
                    apply(w);
                    n_checks++;
                    if (uncorrectable !== 1'b1 || err_count !== 2'd0 || data_out !== w[N-1:PB])
                        fail_line("R5", "S1-zero triple not flagged", uncorrectable, 1);
                    found++;
                end
            end

        // R6/R7: random three-flip patterns
        for (int v = 0; v < 300; v++) begin
            d  = rand_data();
            cw = encode(d);
            pick_distinct(3, p);
            w = cw;
            for (int a = 0; a < 3; a++) w[p[a]] ^= 1'b1;
            apply(w);
            check_three(w);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule